// File: doc/BRIEF.md
# PC-Relative Store Sequencer

This block is a 16-bit datapath built around one shared bus. A small control sequencer drives it through a store whose target address is relative to the program counter. The datapath contains a program counter, an instruction register and an eight-entry register file. It also has an address adder with two selectable operands, an ALU that can pass its first operand through, a bus fed through gated drivers, and two memory-interface registers: an address latch and a write-data latch. The block drives the write side of an external synchronous memory.

Before pulsing `start`, software or a surrounding controller loads the program counter, the instruction word and the register file through the load ports. The sequencer then takes three clock cycles.

- **First cycle:** the effective address (PC plus the sign-extended 9-bit offset in instruction bits 8..0) goes onto the bus and into the address latch.
- **Second cycle:** the source register named by instruction bits 11..9 passes through the ALU onto the bus and into the data latch.
- **Third cycle:** the memory enable and write strobe are raised, and `done` pulses.

Every control signal is visible on the ports so that the per-cycle control can be observed.

Top module: `pcrs_top`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle and clears the program counter, the address latch and the data latch. After reset, `busy`, `done`, `mem_en` and `mem_we` are 0, and `mem_addr` and `mem_wdata` are 0. This holds even when reset arrives in the middle of a store, and an aborted store issues no memory write.
- R2: A `start` sampled while idle causes exactly three busy cycles. `done` is 1 in the third cycle only, and the block is idle again in the cycle after that.
- R3: In the first busy cycle, the controls are set as follows, and `bus_val` carries PC + sext(IR[8:0]):
  - `ofs_sel` = 2. The offset encoding is 0 = zero, 1 = sext IR[5:0], 2 = sext IR[8:0], 3 = sext IR[10:0].
  - `base_sel` = 0, which selects the PC (1 selects the register named by IR[8:6]).
  - `adr_src_sel` = 0, which selects the adder (1 selects the zero-extended IR[7:0]).
  - `gate_adr` = 1, `gate_alu` = 0 and `ld_adr` = 1.
- R4: In the second busy cycle, the controls are set as follows, and `bus_val` carries the value of that register:
  - `rf_rsel1` = IR[11:9].
  - `alu_op` = 3, which is pass-through. The encoding is 0 add, 1 and, 2 not, 3 pass.
  - `gate_alu` = 1 and `gate_adr` = 0.
  - `dat_src_sel` = 0, which selects the bus (1 selects `mem_rdata`).
  - `ld_dat` = 1 and `mem_en` = 0.
- R5: In the third busy cycle, `mem_en` = 1, `mem_we` = 1, `mem_addr` carries the effective address and `mem_wdata` carries the source register value. This is the only cycle of a store in which `mem_we` is 1.
- R6: The offset is sign-extended and the address sum wraps modulo 2^16. Negative offsets, the extreme offsets +255 and -256, and sums that cross zero all produce the correct address.
- R7: At most one bus gate is active in a cycle. When neither gate is active (for example while idle), `bus_val` is 0.
- R8: A `start` held or repeated while busy neither restarts nor lengthens the sequence.
- R9: Program-counter, instruction and register-file loads presented while busy are ignored. A later store that uses the same state writes the same address and data.
- R10: Reset does not alter the register-file contents.
- R11: A latch load asserted in a cycle shows its new value from the following cycle on. `mem_addr` already holds the effective address in the second busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a store when idle |
| pc_wr | input | 1 | Load program counter (ignored while busy) |
| pc_din | input | 16 | Program counter load value |
| ir_wr | input | 1 | Load instruction register (ignored while busy) |
| ir_din | input | 16 | Instruction word |
| rf_wr | input | 1 | Register-file write (ignored while busy) |
| rf_wsel | input | 3 | Register-file write index |
| rf_wdata | input | 16 | Register-file write value |
| mem_rdata | input | 16 | Memory read data, second data-latch source |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Address latch contents |
| mem_wdata | output | 16 | Data latch contents |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequencer not idle |
| bus_val | output | 16 | Shared bus value |
| ofs_sel | output | 2 | Offset operand select |
| base_sel | output | 1 | Base operand select |
| adr_src_sel | output | 1 | Address-latch source select |
| gate_adr | output | 1 | Address path drives the bus |
| gate_alu | output | 1 | ALU drives the bus |
| ld_adr | output | 1 | Address latch load |
| ld_dat | output | 1 | Data latch load |
| dat_src_sel | output | 1 | Data-latch source select |
| alu_op | output | 2 | ALU operation |
| rf_rsel1 | output | 3 | Register-file read port 1 index |

## Verification
Once `start` is sampled idle at a rising edge, the first-cycle controls and the address on `bus_val` appear one edge later. The second-cycle controls, the source value on `bus_val` and the latched address on `mem_addr` appear two edges later. The write strobe, the latched data and `done` appear three edges later, and idle returns four edges later. The bench drives on falling edges and samples each of these results at the falling edge inside the cycle it is due, so a result that is one cycle early or late is a mismatch. A monitor pops the expected address/data pair at each observed write, and any write with nothing queued counts as a mismatch.

// File: rtl/pcrs_pkg.sv
package pcrs_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ADR  = 2'd1,
      SQ_DAT  = 2'd2,
      SQ_WR   = 2'd3
   } sq_state_t;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'd0,
      ALU_AND  = 2'd1,
      ALU_NOT  = 2'd2,
      ALU_PASS = 2'd3
   } alu_op_t;

   localparam logic [1:0] OFS_ZERO = 2'd0;
   localparam logic [1:0] OFS_F6   = 2'd1;
   localparam logic [1:0] OFS_F9   = 2'd2;
   localparam logic [1:0] OFS_F11  = 2'd3;

   typedef struct packed {
      logic [1:0] ofs_sel;
      logic       base_sel;
      logic       adr_src_sel;
      logic       gate_adr;
      logic       gate_alu;
      logic       ld_adr;
      logic       ld_dat;
      logic       dat_src_sel;
      alu_op_t    alu_op;
      logic       mem_en;
      logic       mem_we;
      logic       done;
   } ctl_t;

   function automatic int ofs_field_w(input int idx);
      case (idx)
         1:       return 6;
         2:       return 9;
         default: return 11;
      endcase
   endfunction

endpackage

// File: rtl/pcrs_seq.sv
module pcrs_seq
   import pcrs_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      start,
   output ctl_t      ctl,
   output logic      busy
);

   sq_state_t state_q, state_d;

   always_comb begin
      case (state_q)
         SQ_IDLE: state_d = start ? SQ_ADR : SQ_IDLE;
         SQ_ADR:  state_d = SQ_DAT;
         SQ_DAT:  state_d = SQ_WR;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SQ_IDLE;
      else     state_q <= state_d;
   end

   always_comb begin
      ctl = '0;
      ctl.alu_op = ALU_ADD;
      case (state_q)
         SQ_ADR: begin
            ctl.ofs_sel     = OFS_F9;
            ctl.base_sel    = 1'b0;
            ctl.adr_src_sel = 1'b0;
            ctl.gate_adr    = 1'b1;
            ctl.ld_adr      = 1'b1;
         end
         SQ_DAT: begin
            ctl.alu_op      = ALU_PASS;
            ctl.gate_alu    = 1'b1;
            ctl.dat_src_sel = 1'b0;
            ctl.ld_dat      = 1'b1;
         end
         SQ_WR: begin
            ctl.mem_en = 1'b1;
            ctl.mem_we = 1'b1;
            ctl.done   = 1'b1;
         end
         default: ;
      endcase
   end

   assign busy = (state_q != SQ_IDLE);

   // R2: a start sampled while idle enters the address cycle
   a_r2_start_enters: assert property (@(posedge clk) disable iff (rst)
      (!rst && state_q == SQ_IDLE && start) |=> (state_q == SQ_ADR));

   // R2: done is a single-cycle pulse followed by idle
   a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
      (!rst && ctl.done) |=> (!ctl.done && state_q == SQ_IDLE));

   // R8: once busy, the sequence only advances forward
   a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
      (!rst && state_q == SQ_ADR) |=> (state_q == SQ_DAT));

endmodule

// File: rtl/pcrs_regfile.sv
module pcrs_regfile #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [DW-1:0] rd1,
   output logic [DW-1:0] rd2
);

   logic [DW-1:0] ent [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (we && (waddr == AW'(gi))) q <= wdata;
      end
      assign ent[gi] = q;
   end

   assign rd1 = ent[ra1];
   assign rd2 = ent[ra2];

endmodule

// File: rtl/pcrs_adr_unit.sv
module pcrs_adr_unit
   import pcrs_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] ir,
   input  logic [DW-1:0] pc,
   input  logic [DW-1:0] base_reg,
   input  logic [1:0]    ofs_sel,
   input  logic          base_sel,
   input  logic          adr_src_sel,
   output logic [DW-1:0] adr_out
);

   localparam int NOPT = 4;
   localparam int ZW   = 8;

   logic [DW-1:0] ofs_opt [NOPT];
   logic [DW-1:0] ofs_v;
   logic [DW-1:0] base_v;
   logic [DW-1:0] sum_v;

   assign ofs_opt[0] = '0;

   for (genvar gi = 1; gi < NOPT; gi++) begin : g_sext
      localparam int FW = ofs_field_w(gi);
      assign ofs_opt[gi] = {{(DW-FW){ir[FW-1]}}, ir[FW-1:0]};
   end

   assign ofs_v  = ofs_opt[ofs_sel];
   assign base_v = base_sel ? base_reg : pc;
   assign sum_v  = base_v + ofs_v;

   assign adr_out = adr_src_sel ? {{(DW-ZW){1'b0}}, ir[ZW-1:0]} : sum_v;

endmodule

// File: rtl/pcrs_alu.sv
module pcrs_alu
   import pcrs_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  alu_op_t       op,
   output logic [DW-1:0] y
);

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_AND: y = a & b;
         ALU_NOT: y = ~a;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/pcrs_top.sv
module pcrs_top
   import pcrs_pkg::*;
#(
   parameter int DW       = 16,
   parameter int RF_DEPTH = 8,
   localparam int RA_W    = $clog2(RF_DEPTH)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            pc_wr,
   input  logic [DW-1:0]   pc_din,
   input  logic            ir_wr,
   input  logic [DW-1:0]   ir_din,
   input  logic            rf_wr,
   input  logic [RA_W-1:0] rf_wsel,
   input  logic [DW-1:0]   rf_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            mem_en,
   output logic            mem_we,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic            done,
   output logic            busy,
   output logic [DW-1:0]   bus_val,
   output logic [1:0]      ofs_sel,
   output logic            base_sel,
   output logic            adr_src_sel,
   output logic            gate_adr,
   output logic            gate_alu,
   output logic            ld_adr,
   output logic            ld_dat,
   output logic            dat_src_sel,
   output logic [1:0]      alu_op,
   output logic [RA_W-1:0] rf_rsel1
);

   localparam int SR_LO   = 9;
   localparam int BASE_LO = 6;

   if (DW < 16) begin : g_bad_dw
      $error("pcrs_top: DW must be at least 16");
   end
   if (RF_DEPTH != 8) begin : g_bad_depth
      $error("pcrs_top: instruction fields address exactly eight registers");
   end

   ctl_t          ctl;
   logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q;
   logic [DW-1:0] rd1, rd2, alu_y, adr_y, bus_w, dat_in;
   logic [RA_W-1:0] ra1, ra2;

   pcrs_seq u_seq (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .ctl   (ctl),
      .busy  (busy)
   );

   assign ra1 = ir_q[SR_LO+RA_W-1:SR_LO];
   assign ra2 = ir_q[BASE_LO+RA_W-1:BASE_LO];

   pcrs_regfile #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
      .clk   (clk),
      .we    (rf_wr && !busy),
      .waddr (rf_wsel),
      .wdata (rf_wdata),
      .ra1   (ra1),
      .ra2   (ra2),
      .rd1   (rd1),
      .rd2   (rd2)
   );

   pcrs_adr_unit #(.DW(DW)) u_adr (
      .ir          (ir_q),
      .pc          (pc_q),
      .base_reg    (rd2),
      .ofs_sel     (ctl.ofs_sel),
      .base_sel    (ctl.base_sel),
      .adr_src_sel (ctl.adr_src_sel),
      .adr_out     (adr_y)
   );

   pcrs_alu #(.DW(DW)) u_alu (
      .a  (rd1),
      .b  (rd2),
      .op (ctl.alu_op),
      .y  (alu_y)
   );

   assign bus_w  = ({DW{ctl.gate_adr}} & adr_y) | ({DW{ctl.gate_alu}} & alu_y);
   assign dat_in = ctl.dat_src_sel ? mem_rdata : bus_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
      end else begin
         if (pc_wr && !busy) pc_q  <= pc_din;
         if (ctl.ld_adr)     mar_q <= bus_w;
         if (ctl.ld_dat)     mdr_q <= dat_in;
      end
   end

   always_ff @(posedge clk) begin
      if (ir_wr && !busy && !rst) ir_q <= ir_din;
   end

   assign mem_en      = ctl.mem_en;
   assign mem_we      = ctl.mem_we;
   assign mem_addr    = mar_q;
   assign mem_wdata   = mdr_q;
   assign done        = ctl.done;
   assign bus_val     = bus_w;
   assign ofs_sel     = ctl.ofs_sel;
   assign base_sel    = ctl.base_sel;
   assign adr_src_sel = ctl.adr_src_sel;
   assign gate_adr    = ctl.gate_adr;
   assign gate_alu    = ctl.gate_alu;
   assign ld_adr      = ctl.ld_adr;
   assign ld_dat      = ctl.ld_dat;
   assign dat_src_sel = ctl.dat_src_sel;
   assign alu_op      = ctl.alu_op;
   assign rf_rsel1    = ra1;

   // R7: never two drivers on the bus
   a_r7_one_gate: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.gate_adr, ctl.gate_alu}));

   // R11: the address latch shows the bus value one cycle after its load
   a_r11_adr_latched: assert property (@(posedge clk) disable iff (rst)
      (!rst && ctl.ld_adr) |=> (mar_q == $past(bus_w)));

   // R11: the data latch shows the bus value one cycle after its load
   a_r11_dat_latched: assert property (@(posedge clk) disable iff (rst)
      (!rst && ctl.ld_dat && !ctl.dat_src_sel) |=> (mdr_q == $past(bus_w)));

   // R2: an address load is always followed by a data load
   a_r2_adr_then_dat: assert property (@(posedge clk) disable iff (rst)
      (!rst && ctl.ld_adr) |=> ctl.ld_dat);

   // R5: a write is preceded by a data load
   a_r5_write_after_dat: assert property (@(posedge clk) disable iff (rst)
      (!rst && ctl.ld_dat) |=> (mem_we && mem_en));

   // R9: program counter and instruction are held while busy
   a_r9_pc_held: assert property (@(posedge clk) disable iff (rst)
      (!rst && busy) |=> $stable(pc_q));
   a_r9_ir_held: assert property (@(posedge clk) disable iff (rst)
      (!rst && busy) |=> $stable(ir_q));

endmodule

// File: tb/pcrs_top_tb.sv
`timescale 1ns/1ps
module pcrs_top_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic        pc_wr = 1'b0, ir_wr = 1'b0, rf_wr = 1'b0;
   logic [15:0] pc_din = '0, ir_din = '0, rf_wdata = '0;
   logic [2:0]  rf_wsel = '0;
   logic [15:0] mem_rdata = '0;
   logic        mem_en, mem_we, done, busy;
   logic [15:0] mem_addr, mem_wdata, bus_val;
   logic [1:0]  ofs_sel, alu_op;
   logic        base_sel, adr_src_sel, gate_adr, gate_alu, ld_adr, ld_dat, dat_src_sel;
   logic [2:0]  rf_rsel1;

   always #4 clk = ~clk;

   pcrs_top u_dut (
      .clk(clk), .rst(rst), .start(start),
      .pc_wr(pc_wr), .pc_din(pc_din), .ir_wr(ir_wr), .ir_din(ir_din),
      .rf_wr(rf_wr), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata), .mem_rdata(mem_rdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .done(done), .busy(busy), .bus_val(bus_val), .ofs_sel(ofs_sel),
      .base_sel(base_sel), .adr_src_sel(adr_src_sel), .gate_adr(gate_adr),
      .gate_alu(gate_alu), .ld_adr(ld_adr), .ld_dat(ld_dat),
      .dat_src_sel(dat_src_sel), .alu_op(alu_op), .rf_rsel1(rf_rsel1)
   );

   typedef struct { logic [15:0] a; logic [15:0] d; } wr_t;

   int          n_cmp = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;
   wr_t         exp_q[$];
   logic [15:0] mem_model [logic [15:0]];
   logic [15:0] exp_mem   [logic [15:0]];
   logic [15:0] rf_model [8];
   logic [15:0] cur_pc = '0;
   logic [15:0] cur_ir = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] eff_adr(input logic [15:0] pc, input logic [15:0] ir);
      return pc + {{7{ir[8]}}, ir[8:0]};
   endfunction

   // monitor: every observed write must match the oldest queued expectation
   always @(negedge clk) begin
      if (mem_en === 1'b1 && mem_we === 1'b1) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_fail++;
            $display("FAIL R5 unexpected write actual=%0h expected=none", mem_addr);
         end else begin
            wr_t e;
            e = exp_q.pop_front();
            chk("R5 write address", mem_addr, e.a);
            chk("R5 write data", mem_wdata, e.d);
         end
         mem_model[mem_addr] = mem_wdata;
      end
   end

   task automatic do_store(input bit reload, input logic [15:0] pc, input logic [15:0] ir,
                           input bit hold_start, input bit poke);
      wr_t e;
      if (reload) begin
         @(negedge clk);
         pc_wr = 1'b1; pc_din = pc; ir_wr = 1'b1; ir_din = ir;
         @(negedge clk);
         pc_wr = 1'b0; ir_wr = 1'b0;
         cur_pc = pc; cur_ir = ir;
      end
      e.a = eff_adr(cur_pc, cur_ir);
      e.d = rf_model[cur_ir[11:9]];
      exp_q.push_back(e);
      exp_mem[e.a] = e.d;
      start = 1'b1;
      @(negedge clk);
      if (!hold_start) start = 1'b0;
      if (poke) begin
         pc_wr = 1'b1; pc_din = 16'hDEAD;
         ir_wr = 1'b1; ir_din = 16'h0E1F;
         rf_wr = 1'b1; rf_wsel = cur_ir[11:9]; rf_wdata = 16'hBAD0;
      end
      // first busy cycle
      chk("R2 busy c1", busy, 1);
      chk("R2 done c1", done, 0);
      chk("R3 ofs_sel", ofs_sel, 2);
      chk("R3 base_sel", base_sel, 0);
      chk("R3 adr_src_sel", adr_src_sel, 0);
      chk("R3 gate_adr", gate_adr, 1);
      chk("R3 gate_alu", gate_alu, 0);
      chk("R3 ld_adr", ld_adr, 1);
      chk("R3 bus effective address", bus_val, e.a);
      chk("R5 mem_en c1", mem_en, 0);
      @(negedge clk);
      if (hold_start) start = 1'b0;
      // second busy cycle
      chk("R2 done c2", done, 0);
      chk("R4 rf_rsel1", rf_rsel1, cur_ir[11:9]);
      chk("R4 alu_op", alu_op, 3);
      chk("R4 gate_alu", gate_alu, 1);
      chk("R4 gate_adr", gate_adr, 0);
      chk("R4 dat_src_sel", dat_src_sel, 0);
      chk("R4 ld_dat", ld_dat, 1);
      chk("R4 mem_en c2", mem_en, 0);
      chk("R4 bus source value", bus_val, e.d);
      chk("R11 address latched", mem_addr, e.a);
      @(negedge clk);
      // third busy cycle
      chk("R2 done c3", done, 1);
      chk("R5 mem_en c3", mem_en, 1);
      chk("R5 mem_we c3", mem_we, 1);
      chk("R7 no gate c3", {gate_adr, gate_alu}, 0);
      chk("R11 data latched", mem_wdata, e.d);
      @(negedge clk);
      pc_wr = 1'b0; ir_wr = 1'b0; rf_wr = 1'b0;
      chk("R2 idle after", busy, 0);
      chk("R2 done cleared", done, 0);
      chk("R8 no restart mem_we", mem_we, 0);
      chk("R7 idle bus zero", bus_val, 0);
   endtask

   initial begin : wd
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", busy, 0);
      chk("R1 done", done, 0);
      chk("R1 mem_en", mem_en, 0);
      chk("R1 mem_we", mem_we, 0);
      chk("R1 mem_addr", mem_addr, 0);
      chk("R1 mem_wdata", mem_wdata, 0);
      chk("R7 idle bus", bus_val, 0);

      for (int i = 0; i < 8; i++) begin
         rf_wr = 1'b1; rf_wsel = 3'(i); rf_wdata = 16'hA000 + 16'(i * 16'h0111);
         rf_model[i] = rf_wdata;
         @(negedge clk);
      end
      rf_wr = 1'b0;

      // R3/R4/R5 basic positive offset
      do_store(1'b1, 16'h3000, {4'b0011, 3'd2, 9'h005}, 1'b0, 1'b0);
      // R6 negative offset crossing below zero
      do_store(1'b1, 16'h0002, {4'b0011, 3'd7, 9'h1FB}, 1'b0, 1'b0);
      // R6 largest positive offset wrapping past the top
      do_store(1'b1, 16'hFFF0, {4'b0011, 3'd0, 9'h0FF}, 1'b0, 1'b0);
      // R6 most negative offset landing on zero
      do_store(1'b1, 16'h0100, {4'b0011, 3'd5, 9'h100}, 1'b0, 1'b0);
      // R8 start held, R9 loads attempted while busy
      do_store(1'b1, 16'h1234, {4'b0011, 3'd3, 9'h010}, 1'b1, 1'b1);
      // R9 repeat without reload: same state must give same write
      do_store(1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);

      // R1 reset in the middle of a store: no write, idle, latches cleared
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 mid reset busy", busy, 0);
      chk("R1 mid reset mem_we", mem_we, 0);
      chk("R1 mid reset mem_addr", mem_addr, 0);
      chk("R1 mid reset mem_wdata", mem_wdata, 0);
      @(negedge clk);
      chk("R1 no write after abort", mem_we, 0);

      // R10 register file survives reset
      do_store(1'b1, 16'h4000, {4'b0011, 3'd6, 9'h001}, 1'b0, 1'b0);
      do_store(1'b1, 16'h4100, {4'b0011, 3'd1, 9'h1FF}, 1'b0, 1'b0);

      repeat (2) @(negedge clk);
      chk("R5 queue drained", exp_q.size(), 0);
      foreach (exp_mem[a]) begin
         if (mem_model.exists(a)) chk("R5 memory content", mem_model[a], exp_mem[a]);
         else chk("R5 memory written", 32'h1, 32'h0);
      end

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule